// File: doc/BRIEF.md
# Software Interrupt Level Arbiter

This block keeps a 32-bit software interrupt register for a processor core and merges it with sixteen external interrupt-level lines. The merged vector goes through a priority scan, and the winning level becomes a trap code in the external-interrupt range, together with a request line for the core. The register has three write operations and one read view. Each write operation has its own address. The write operand is the XOR of two source words, cut to 32 bits. All writes need supervisor privilege. A write attempt without privilege raises an illegal-instruction flag and leaves the register unchanged. A timer-match pulse sets bit 0 of the register, and bit 0 counts as level 14.

The block also holds a single recorded trap code. A non-external trap code posted by the core takes precedence over external levels and is not replaced by them. An acknowledge from the core empties the slot when the trap is taken. A rising external line produces a one-cycle wake pulse, which takes the core out of its halted state.

Timing: a register write is visible one edge after it is issued. The recorded code follows the merged vector one edge later, so a write reaches the trap code after two edges. A change on the external lines reaches the trap code after one edge.

Top module: `softint_level_arb`

## Requirements
- R1: With privilege, a write to address 0x14 ORs the operand (low 32 bits of src_a XOR src_b) into the register at the next edge.
- R2: With privilege, a write to address 0x15 clears every register bit that is 1 in the operand.
- R3: With privilege, a write to address 0x16 replaces the register with the operand. rd_data shows the register when rd_addr is 0x16 and reads 0 for any other address.
- R4: A write to 0x14, 0x15 or 0x16 without privilege leaves the register unchanged and pulses illegal for one cycle at the next edge. A write to any other address is ignored and does not raise illegal.
- R5: timer_hit sets register bit 0. If a clear or overwrite in the same cycle targets bit 0, the timer still leaves bit 0 set.
- R6: The pending vector is formed from the external lines, register bits 15..1, and register bit 0, which is placed on level 14. Register bits 31..16 produce no level.
- R7: The highest pending level from 15 down to 1 wins, and the trap code is 0x40 + level. A pending vector that has only level 0 neither loads a level nor clears a recorded external code.
- R8: irq_req is high exactly when the recorded trap code is nonzero.
- R9: post_valid loads post_code at the next edge. Posted codes must have an upper nibble other than 4. Post has priority over take_ack. take_ack empties the slot. Pending levels never replace a recorded non-external code.
- R10: If the recorded code is external (0x41..0x4F) and the pending vector is all zero, the code returns to 0 at the next edge.
- R11: wake pulses for one cycle at the edge after any external line goes from 0 to 1. A falling line produces no pulse.
- R12: Synchronous reset clears the register, the recorded code, irq_req, illegal and wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address (0x14 set, 0x15 clear, 0x16 overwrite) |
| src_a | input | SRC_W | First source operand |
| src_b | input | SRC_W | Second source operand |
| priv | input | 1 | Supervisor privilege for the write |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Register value when rd_addr is 0x16, else 0 |
| timer_hit | input | 1 | Timer-match pulse, sets bit 0 |
| ext_level | input | 16 | External interrupt-level lines |
| post_valid | input | 1 | Post a non-external trap code |
| post_code | input | 8 | Code to post |
| take_ack | input | 1 | Core took the recorded trap |
| trap_code | output | 8 | Recorded trap code |
| irq_req | output | 1 | Interrupt request to the core |
| illegal | output | 1 | Unprivileged write attempt flag |
| wake | output | 1 | Wake pulse on a rising external line |

## Verification
A timer-match pulse and a clear or overwrite of bit 0 can land in the same cycle. The bench provokes this by driving timer_hit together with a clear of bit 0. It then checks that bit 0 reads back as 1 and that the trap code settles on 0x4E. A posted code and a take acknowledge can also coincide. In that case the bench expects the posted code in the slot after the edge.

// File: rtl/sil_pkg.sv
package sil_pkg;

    localparam int REG_W      = 32;
    localparam int LVL_N      = 16;
    localparam int LVL_W      = $clog2(LVL_N);
    localparam int TRAP_W     = 8;
    localparam int ADDR_W     = 5;
    localparam int TIMER_BIT  = 0;
    localparam int TIMER_LVL  = 14;

    localparam logic [TRAP_W-1:0] EXT_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] ADDR_SET = 5'h14;
    localparam logic [ADDR_W-1:0] ADDR_CLR = 5'h15;
    localparam logic [ADDR_W-1:0] ADDR_WR  = 5'h16;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SET,
        OP_CLR,
        OP_WR
    } sw_op_e;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
    } lvl_pick_t;

    function automatic sw_op_e decode_op(input logic en, input logic [ADDR_W-1:0] addr);
        sw_op_e op;
        op = OP_NONE;
        if (en) begin
            case (addr)
                ADDR_SET: op = OP_SET;
                ADDR_CLR: op = OP_CLR;
                ADDR_WR:  op = OP_WR;
                default:  op = OP_NONE;
            endcase
        end
        return op;
    endfunction

    function automatic logic is_ext(input logic [TRAP_W-1:0] code);
        return code[TRAP_W-1:LVL_W] == EXT_BASE[TRAP_W-1:LVL_W];
    endfunction

    function automatic logic [LVL_N-1:0] merge_pending(
        input logic [LVL_N-1:0] ext,
        input logic [LVL_N-1:0] sw_lo
    );
        logic [LVL_N-1:0] m;
        m = ext | (sw_lo & ~(LVL_N'(1) << TIMER_BIT));
        m[TIMER_LVL] = m[TIMER_LVL] | sw_lo[TIMER_BIT];
        return m;
    endfunction

endpackage

// File: rtl/sil_softreg.sv
module sil_softreg
    import sil_pkg::*;
#(
    parameter int SRC_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SRC_W-1:0]  src_a,
    input  logic [SRC_W-1:0]  src_b,
    input  logic              priv,
    input  logic              timer_hit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  sw_q,
    output logic [REG_W-1:0]  rd_data,
    output logic              illegal
);

    sw_op_e           op;
    logic [REG_W-1:0] operand;
    logic [REG_W-1:0] sw_nxt;

    always_comb begin
        op      = decode_op(wr_en, wr_addr);
        operand = REG_W'(src_a ^ src_b);
        sw_nxt  = sw_q;
        if (priv) begin
            case (op)
                OP_SET:  sw_nxt = sw_q | operand;
                OP_CLR:  sw_nxt = sw_q & ~operand;
                OP_WR:   sw_nxt = operand;
                default: sw_nxt = sw_q;
            endcase
        end
        if (timer_hit) begin
            sw_nxt[TIMER_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q    <= '0;
            illegal <= 1'b0;
        end else begin
            sw_q    <= sw_nxt;
            illegal <= (op != OP_NONE) && !priv;
        end
    end

    assign rd_data = (rd_addr == ADDR_WR) ? sw_q : '0;

endmodule

// File: rtl/sil_prio_enc.sv
module sil_prio_enc
    import sil_pkg::*;
(
    input  logic [LVL_N-1:0] pend,
    output lvl_pick_t        pick
);

    always_comb begin
        pick = '0;
        for (int i = 1; i < LVL_N; i++) begin
            if (pend[i]) begin
                pick.valid = 1'b1;
                pick.level = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/sil_trap_slot.sv
module sil_trap_slot
    import sil_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lvl_pick_t         pick,
    input  logic              pend_zero,
    input  logic              post_valid,
    input  logic [TRAP_W-1:0] post_code,
    input  logic              take_ack,
    output logic [TRAP_W-1:0] trap_code,
    output logic              irq_req
);

    logic [TRAP_W-1:0] code_nxt;

    always_comb begin
        code_nxt = trap_code;
        if (post_valid) begin
            code_nxt = post_code;
        end else if (take_ack) begin
            code_nxt = '0;
        end else if (pick.valid && (trap_code == '0 || is_ext(trap_code))) begin
            code_nxt = EXT_BASE | TRAP_W'(pick.level);
        end else if (pend_zero && is_ext(trap_code)) begin
            code_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_code <= '0;
            irq_req   <= 1'b0;
        end else begin
            trap_code <= code_nxt;
            irq_req   <= (code_nxt != '0);
        end
    end

endmodule

// File: rtl/sil_wake.sv
module sil_wake
    import sil_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_N-1:0] ext_level,
    output logic [LVL_N-1:0] prev_q,
    output logic             wake
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            wake   <= 1'b0;
        end else begin
            prev_q <= ext_level;
            wake   <= |(ext_level & ~prev_q);
        end
    end

endmodule

// File: rtl/softint_level_arb.sv
module softint_level_arb
    import sil_pkg::*;
#(
    parameter int SRC_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SRC_W-1:0]  src_a,
    input  logic [SRC_W-1:0]  src_b,
    input  logic              priv,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              timer_hit,
    input  logic [LVL_N-1:0]  ext_level,
    input  logic              post_valid,
    input  logic [TRAP_W-1:0] post_code,
    input  logic              take_ack,
    output logic [TRAP_W-1:0] trap_code,
    output logic              irq_req,
    output logic              illegal,
    output logic              wake
);

    logic [REG_W-1:0] sw_q;
    logic [LVL_N-1:0] pend;
    logic [LVL_N-1:0] ext_prev;
    lvl_pick_t        pick;

    sil_softreg #(.SRC_W(SRC_W)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .src_a     (src_a),
        .src_b     (src_b),
        .priv      (priv),
        .timer_hit (timer_hit),
        .rd_addr   (rd_addr),
        .sw_q      (sw_q),
        .rd_data   (rd_data),
        .illegal   (illegal)
    );

    assign pend = merge_pending(ext_level, sw_q[LVL_N-1:0]);

    sil_prio_enc u_enc (
        .pend (pend),
        .pick (pick)
    );

    sil_trap_slot u_slot (
        .clk        (clk),
        .rst        (rst),
        .pick       (pick),
        .pend_zero  (pend == '0),
        .post_valid (post_valid),
        .post_code  (post_code),
        .take_ack   (take_ack),
        .trap_code  (trap_code),
        .irq_req    (irq_req)
    );

    sil_wake u_wake (
        .clk       (clk),
        .rst       (rst),
        .ext_level (ext_level),
        .prev_q    (ext_prev),
        .wake      (wake)
    );

endmodule

// File: rtl/sil_checker.sv
module sil_checker
    import sil_pkg::*;
#(
    parameter int SRC_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [SRC_W-1:0]  src_a,
    input logic [SRC_W-1:0]  src_b,
    input logic              priv,
    input logic              timer_hit,
    input logic [LVL_N-1:0]  ext_level,
    input logic [LVL_N-1:0]  ext_prev,
    input logic [LVL_N-1:0]  pend,
    input logic              post_valid,
    input logic              take_ack,
    input logic [REG_W-1:0]  sw_q,
    input logic [TRAP_W-1:0] trap_code,
    input logic              irq_req,
    input logic              illegal,
    input logic              wake
);

    logic [REG_W-1:0] op_c;
    logic             is_wr_addr;
    assign op_c       = REG_W'(src_a ^ src_b);
    assign is_wr_addr = (wr_addr == ADDR_SET) || (wr_addr == ADDR_CLR) || (wr_addr == ADDR_WR);

    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_SET && priv && !timer_hit) |=> (sw_q == ($past(sw_q) | $past(op_c))));

    assert_clr_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CLR && priv && !timer_hit) |=> (sw_q == ($past(sw_q) & ~$past(op_c))));

    assert_wr_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_WR && priv && !timer_hit) |=> (sw_q == $past(op_c)));

    assert_illegal_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_wr_addr && !priv && !timer_hit) |=> (illegal && sw_q == $past(sw_q)));

    assert_timer_R5: assert property (@(posedge clk) disable iff (rst)
        timer_hit |=> sw_q[TIMER_BIT]);

    assert_no_lvl0_R7: assert property (@(posedge clk) disable iff (rst)
        is_ext(trap_code) |-> (trap_code[LVL_W-1:0] != '0));

    assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
        irq_req == (trap_code != '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (trap_code != '0 && !is_ext(trap_code) && !post_valid && !take_ack) |=> $stable(trap_code));

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (is_ext(trap_code) && pend == '0 && !post_valid && !take_ack) |=> (trap_code == '0));

    assert_wake_R11: assert property (@(posedge clk) disable iff (rst)
        (|(ext_level & ~ext_prev)) |=> wake);

    assert_reset_R12: assert property (@(posedge clk)
        rst |=> (trap_code == '0 && !irq_req && sw_q == '0 && !illegal && !wake));

endmodule

bind softint_level_arb sil_checker #(.SRC_W(SRC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .src_a      (src_a),
    .src_b      (src_b),
    .priv       (priv),
    .timer_hit  (timer_hit),
    .ext_level  (ext_level),
    .ext_prev   (ext_prev),
    .pend       (pend),
    .post_valid (post_valid),
    .take_ack   (take_ack),
    .sw_q       (sw_q),
    .trap_code  (trap_code),
    .irq_req    (irq_req),
    .illegal    (illegal),
    .wake       (wake)
);

// File: tb/softint_level_arb_bench.sv
module softint_level_arb_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic        priv;
    logic [4:0]  rd_addr;
    logic [31:0] rd_data;
    logic        timer_hit;
    logic [15:0] ext_level;
    logic        post_valid;
    logic [7:0]  post_code;
    logic        take_ack;
    logic [7:0]  trap_code;
    logic        irq_req;
    logic        illegal;
    logic        wake;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    softint_level_arb u_softint_level_arb (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .src_a      (src_a),
        .src_b      (src_b),
        .priv       (priv),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .timer_hit  (timer_hit),
        .ext_level  (ext_level),
        .post_valid (post_valid),
        .post_code  (post_code),
        .take_ack   (take_ack),
        .trap_code  (trap_code),
        .irq_req    (irq_req),
        .illegal    (illegal),
        .wake       (wake)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [63:0] a;
        logic [63:0] b;
        logic        pv;
        logic        tmr;
        logic [15:0] ext;
        logic [31:0] sw;
        logic        ill;
        logic [7:0]  trap;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{5'h14, 64'h0000_0000_0000_0008, 64'h0, 1'b1, 1'b0, 16'h0000, 32'h0000_0008, 1'b0, 8'h43},
        '{5'h14, 64'h1234_5678_0000_0100, 64'h0, 1'b1, 1'b0, 16'h0000, 32'h0000_0108, 1'b0, 8'h48},
        '{5'h15, 64'h0000_0000_0000_0100, 64'h0, 1'b1, 1'b0, 16'h0000, 32'h0000_0008, 1'b0, 8'h43},
        '{5'h16, 64'h0000_0000_0000_0001, 64'h0, 1'b1, 1'b0, 16'h0000, 32'h0000_0001, 1'b0, 8'h4E},
        '{5'h14, 64'h0000_0000_0000_8000, 64'h0, 1'b0, 1'b0, 16'h0000, 32'h0000_0001, 1'b1, 8'h4E},
        '{5'h00, 64'h0000_0000_0000_FFFF, 64'h0, 1'b0, 1'b0, 16'h0020, 32'h0000_0001, 1'b0, 8'h4E},
        '{5'h16, 64'h0000_0000_0000_8000, 64'h0, 1'b1, 1'b0, 16'h0020, 32'h0000_8000, 1'b0, 8'h4F},
        '{5'h16, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF, 1'b1, 1'b0, 16'h0020, 32'h0000_0000, 1'b0, 8'h45},
        '{5'h16, 64'h0, 64'h0, 1'b1, 1'b0, 16'h0000, 32'h0000_0000, 1'b0, 8'h00},
        '{5'h00, 64'h0, 64'h0, 1'b0, 1'b1, 16'h0000, 32'h0000_0001, 1'b0, 8'h4E},
        '{5'h15, 64'h0000_0000_0000_0001, 64'h0, 1'b1, 1'b1, 16'h0000, 32'h0000_0001, 1'b0, 8'h4E},
        '{5'h16, 64'h0, 64'h0, 1'b1, 1'b0, 16'h0001, 32'h0000_0000, 1'b0, 8'h4E},
        '{5'h16, 64'h0000_0000_0001_0000, 64'h0, 1'b1, 1'b0, 16'h0000, 32'h0001_0000, 1'b0, 8'h00},
        '{5'h16, 64'h0000_0000_FFFF_FFFE, 64'h0, 1'b1, 1'b0, 16'h0000, 32'hFFFF_FFFE, 1'b0, 8'h4F},
        '{5'h15, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 16'h0000, 32'h0000_0000, 1'b0, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write(input logic [4:0] addr, input logic [63:0] a, input logic [63:0] b, input logic p);
        wr_en = 1'b1; wr_addr = addr; src_a = a; src_b = b; priv = p;
        tick();
        wr_en = 1'b0; src_a = '0; src_b = '0; priv = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; src_a = '0; src_b = '0; priv = 1'b0;
        rd_addr = 5'h16; timer_hit = 1'b0; ext_level = '0;
        post_valid = 1'b0; post_code = '0; take_ack = 1'b0;
        tick(); tick();
        rst = 1'b0;
        check("R12 reset trap", {24'h0, trap_code}, 32'h0);
        check("R12 reset irq", {31'h0, irq_req}, 32'h0);
        check("R12 reset reg", rd_data, 32'h0);
        check("R12 reset illegal/wake", {30'h0, illegal, wake}, 32'h0);

        // R1 R2 R3 R4 R5 R6 R7 R10: table walk
        for (int i = 0; i < NV; i++) begin
            wr_en = 1'b1; wr_addr = VECS[i].addr; src_a = VECS[i].a; src_b = VECS[i].b;
            priv = VECS[i].pv; timer_hit = VECS[i].tmr; ext_level = VECS[i].ext;
            tick();
            wr_en = 1'b0; timer_hit = 1'b0;
            check($sformatf("R1/R2/R3/R5 reg vec%0d", i), rd_data, VECS[i].sw);
            check($sformatf("R4 illegal vec%0d", i), {31'h0, illegal}, {31'h0, VECS[i].ill});
            tick();
            check($sformatf("R6/R7/R10 trap vec%0d", i), {24'h0, trap_code}, {24'h0, VECS[i].trap});
            check($sformatf("R8 irq vec%0d", i), {31'h0, irq_req}, {31'h0, VECS[i].trap != 8'h0});
        end
        ext_level = '0;

        // R3: read at non-readable address returns 0
        write(5'h16, 64'h3, 64'h0, 1'b1);
        rd_addr = 5'h14;
        #1 check("R3 read other addr", rd_data, 32'h0);
        rd_addr = 5'h16;
        #1 check("R3 read reg addr", rd_data, 32'h3);
        write(5'h16, 64'h0, 64'h0, 1'b1);
        tick();
        check("R10 cleared after overwrite", {24'h0, trap_code}, 32'h0);

        // R9: posted code protected, take_ack, post beats take
        post_valid = 1'b1; post_code = 8'h30;
        tick();
        post_valid = 1'b0;
        check("R9 post loads", {24'h0, trap_code}, 32'h30);
        check("R8 irq on post", {31'h0, irq_req}, 32'h1);
        write(5'h14, 64'h20, 64'h0, 1'b1);
        tick(); tick();
        check("R9 level does not replace posted", {24'h0, trap_code}, 32'h30);
        take_ack = 1'b1;
        tick();
        take_ack = 1'b0;
        check("R9 take clears", {24'h0, trap_code}, 32'h0);
        check("R8 irq low after take", {31'h0, irq_req}, 32'h0);
        tick();
        check("R7 level 5 relatched", {24'h0, trap_code}, 32'h45);
        post_valid = 1'b1; post_code = 8'h31; take_ack = 1'b1;
        tick();
        post_valid = 1'b0; take_ack = 1'b0;
        check("R9 post wins over take", {24'h0, trap_code}, 32'h31);
        take_ack = 1'b1;
        tick();
        take_ack = 1'b0;
        write(5'h15, 64'h20, 64'h0, 1'b1);
        tick();
        check("R10 empty after clear", {24'h0, trap_code}, 32'h0);

        // R11: wake on rising lines only
        ext_level = 16'h0004;
        tick();
        check("R11 wake on rise", {31'h0, wake}, 32'h1);
        check("R7 ext level 2", {24'h0, trap_code}, 32'h42);
        tick();
        check("R11 wake one cycle", {31'h0, wake}, 32'h0);
        ext_level = 16'h0006;
        tick();
        check("R11 wake second line", {31'h0, wake}, 32'h1);
        ext_level = 16'h0002;
        tick();
        check("R11 no wake on fall", {31'h0, wake}, 32'h0);
        ext_level = '0;
        tick();
        check("R10 ext drop clears", {24'h0, trap_code}, 32'h0);

        // R12: reset mid-operation
        write(5'h16, 64'hFFFF, 64'h0, 1'b1);
        write(5'h14, 64'h1, 64'h0, 1'b0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R12 reset reg", rd_data, 32'h0);
        check("R12 reset trap", {24'h0, trap_code}, 32'h0);
        check("R12 reset illegal", {31'h0, illegal}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule